// File: doc/BRIEF.md
# Three-Operand Integer Adder

This execution unit adds three 32-bit integer sources in a single operation and registers the result. Alongside the three operand values it receives the 64-bit instruction word of the operation and a two-bit form code that says whether the sources came from registers, from a constant bank or from an immediate. Some instruction fields pick, for each source, the full word, its low half or its high half. Other fields negate any source. A mode field shifts the partial sum of the first two sources by sixteen bits, left or right, before the third source is added.

Half-word selection and the shift mode are honoured only in the register form. In the constant and immediate forms the unit adds the three sources, each negated if its flag asks for it. The sum wraps modulo 2^32. A reserved field code in the register form raises an illegal-encoding flag with the result, and the unit then handles that field as code 0. The unit takes a new operation on any cycle where in_valid is high and presents its answer one clock later.

Top module: `tri_add_unit`

## Requirements
- R1: Form code 0 is the register form; codes 1 (constant), 2 (immediate) and 3 are all non-register forms. In a non-register form the result is the sum of the three sources, each negated if its flag is set. The half-word fields and the mode field are ignored and never flag illegal.
- R2: In the register form, each source has a two-bit half-word field: A at insn[36:35], B at insn[34:33], C at insn[32:31]. Code 0 passes the full word. Code 1 keeps bits 15:0, zero-extended. Code 2 moves bits 31:16 down to 15:0 with zero fill above.
- R3: A source is negated (two's complement) when its flag is set: A at insn[51], B at insn[50], C at insn[49]. In the register form the negation is applied after the half-word selection.
- R4: In the register form the mode field is insn[38:37]. With mode 0 the result is A+B+C.
- R5: Mode 1 forms A+B at 33 bits, keeping the carry. It shifts that sum right by 16 logically, then adds C. For example, A=0xFFFFFFFF, B=1, C=0 gives 0x00010000.
- R6: Mode 2 shifts the 32-bit A+B left by 16, drops the bits above bit 31, then adds C.
- R7: In the register form, half-word code 3 on any source or mode code 3 sets illegal for that operation. The reserved field then behaves as code 0. Otherwise illegal is 0.
- R8: An operation accepted with in_valid high appears on result and illegal one clock later, with out_valid high for exactly that cycle. If in_valid is low, out_valid is low on the next cycle.
- R9: A synchronous reset clears out_valid.
- R10: While no operation is accepted, result keeps its last value.
- R11: The result wraps modulo 2^32, and overflow is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| form | input | 2 | Operand form: 0 register, 1 constant, 2 immediate, 3 non-register |
| insn | input | 64 | Instruction word carrying half-word, mode and negate fields |
| src_a | input | 32 | Source A |
| src_b | input | 32 | Source B |
| src_c | input | 32 | Source C |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Sum |
| illegal | output | 1 | Reserved encoding seen in the register form |

## Verification
The bound checker watches, on every cycle, the one-cycle relation between in_valid and out_valid, the clearing of out_valid by reset, and the holding of result while the unit is idle. It also checks that the plain three-way sum appears whenever no field changes the operation, and that illegal never rises in a non-register form. The half-word selection, the order of selection before negation, the carry kept by the right shift, the bits dropped by the left shift and the reserved-code fallback are shown only by the bench's scenarios. The bench compares each result against its own model, and against hand-computed values at the corner cases.

// File: rtl/tri_add_unit.sv
module tri_add_unit #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    form,
  input  logic [63:0]   insn,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic [W-1:0]  src_c,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          illegal
);
  localparam int HW = W / 2;
  localparam logic [1:0] FORM_REG = 2'd0;

  function automatic logic [W-1:0] pick_half(input logic [1:0] h, input logic [W-1:0] x);
    case (h)
      2'd1:    pick_half = {{HW{1'b0}}, x[HW-1:0]};
      2'd2:    pick_half = {{HW{1'b0}}, x[W-1:HW]};
      default: pick_half = x;
    endcase
  endfunction

  logic          is_reg;
  logic [1:0]    h_a, h_b, h_c, mode;
  logic [W-1:0]  sel_a, sel_b, sel_c;
  logic [W-1:0]  op_a, op_b, op_c;
  logic [W:0]    sum_ab;
  logic [W-1:0]  partial;
  logic          bad_code;
  logic          unused_bits;

  assign unused_bits = ^{insn[63:52], insn[48:39], insn[30:0]};

  assign is_reg = (form == FORM_REG);
  assign h_a  = is_reg ? insn[36:35] : 2'd0;
  assign h_b  = is_reg ? insn[34:33] : 2'd0;
  assign h_c  = is_reg ? insn[32:31] : 2'd0;
  assign mode = is_reg ? insn[38:37] : 2'd0;

  assign sel_a = pick_half(h_a, src_a);
  assign sel_b = pick_half(h_b, src_b);
  assign sel_c = pick_half(h_c, src_c);

  assign op_a = insn[51] ? (~sel_a + 1'b1) : sel_a;
  assign op_b = insn[50] ? (~sel_b + 1'b1) : sel_b;
  assign op_c = insn[49] ? (~sel_c + 1'b1) : sel_c;

  assign sum_ab = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    case (mode)
      2'd1:    partial = W'(sum_ab >> HW);
      2'd2:    partial = {sum_ab[HW-1:0], {HW{1'b0}}};
      default: partial = sum_ab[W-1:0];
    endcase
  end

  assign bad_code = (h_a == 2'd3) || (h_b == 2'd3) || (h_c == 2'd3) || (mode == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= partial + op_c;
        illegal <= bad_code;
      end
    end
  end
endmodule

module tri_add_unit_chk #(
  parameter int W = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    form,
  input logic [63:0]   insn,
  input logic [W-1:0]  src_a,
  input logic [W-1:0]  src_b,
  input logic [W-1:0]  src_c,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          illegal
);
  logic unused_insn;
  assign unused_insn = ^{insn[63:52], insn[48:39], insn[30:0]};

  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R1
  nonreg_no_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form != 2'd0) |=> !illegal);

  // R4
  plain_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[51:49] == 3'b000 && (form != 2'd0 || insn[38:31] == 8'd0))
      |=> result == $past(src_a + src_b + src_c));
endmodule

bind tri_add_unit tri_add_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_tri_add_unit.sv
module tb_tri_add_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  form;
  logic [63:0] insn;
  logic [31:0] src_a, src_b, src_c;
  logic        out_valid;
  logic [31:0] result;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tri_add_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form(form), .insn(insn),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [63:0] mk(input logic [1:0] ha, input logic [1:0] hb,
                                     input logic [1:0] hc, input logic [1:0] md,
                                     input logic na, input logic nb, input logic nc);
    logic [63:0] w = 64'h0;
    w[36:35] = ha; w[34:33] = hb; w[32:31] = hc; w[38:37] = md;
    w[51] = na; w[50] = nb; w[49] = nc;
    return w;
  endfunction

  function automatic logic [31:0] half_of(input logic [1:0] h, input logic [31:0] x);
    if (h == 2'd1) return x & 32'h0000FFFF;
    if (h == 2'd2) return x >> 16;
    return x;
  endfunction

  function automatic logic [32:0] model(input logic [1:0] f, input logic [63:0] w,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    bit reg_form = (f == 2'd0);
    logic [1:0] ha = reg_form ? w[36:35] : 2'd0;
    logic [1:0] hb = reg_form ? w[34:33] : 2'd0;
    logic [1:0] hc = reg_form ? w[32:31] : 2'd0;
    logic [1:0] md = reg_form ? w[38:37] : 2'd0;
    logic [31:0] xa = half_of(ha, a);
    logic [31:0] xb = half_of(hb, b);
    logic [31:0] xc = half_of(hc, c);
    longint unsigned pab, p;
    logic [31:0] r;
    logic ill;
    if (w[51]) xa = 32'd0 - xa;
    if (w[50]) xb = 32'd0 - xb;
    if (w[49]) xc = 32'd0 - xc;
    pab = longint'(xa) + longint'(xb);
    if (md == 2'd1)      p = pab / 65536;
    else if (md == 2'd2) p = (pab % 65536) * 65536;
    else                 p = pab;
    r = 32'(p + longint'(xc));
    ill = reg_form && (ha == 2'd3 || hb == 2'd3 || hc == 2'd3 || md == 2'd3);
    return {ill, r};
  endfunction

  task automatic issue(input string tag, input logic [1:0] f, input logic [63:0] w,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic [32:0] expv);
    @(negedge clk);
    in_valid = 1'b1; form = f; insn = w; src_a = a; src_b = b; src_c = c;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic drive(input string tag, input logic [1:0] f, input logic [63:0] w,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    issue(tag, f, w, a, b, c, model(f, w, a, b, c));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) check("R8 unexpected out_valid", 33'd1, 33'd0);
        else check(tag_q.pop_front(), {illegal, result}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; in_valid = 1'b0; form = 2'd0; insn = 64'h0;
    src_a = 0; src_b = 0; src_c = 0;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {32'd0, out_valid}, 33'd0);
    rst = 1'b0;

    // R4 plain sum and R11 wrap
    issue("R4 mode0 sum", 2'd0, mk(0,0,0,0,0,0,0), 32'd10, 32'd20, 32'd30, {1'b0, 32'd60});
    issue("R11 wrap", 2'd0, mk(0,0,0,0,0,0,0), 32'hFFFFFFFF, 32'h2, 32'h3, {1'b0, 32'd4});
    // R2 half-word selection
    issue("R2 low half A", 2'd0, mk(1,0,0,0,0,0,0), 32'h1234ABCD, 32'd0, 32'd0, {1'b0, 32'h0000ABCD});
    issue("R2 high half B", 2'd0, mk(0,2,0,0,0,0,0), 32'd0, 32'h1234ABCD, 32'd1, {1'b0, 32'h00001235});
    drive("R2 mixed halves", 2'd0, mk(2,1,2,0,0,0,0), 32'hDEADBEEF, 32'hCAFEF00D, 32'h87654321);
    // R3 negation after selection
    issue("R3 neg after low half", 2'd0, mk(1,0,0,0,1,0,0), 32'hFFFF0001, 32'd0, 32'd0, {1'b0, 32'hFFFFFFFF});
    issue("R3 neg C", 2'd0, mk(0,0,0,0,0,0,1), 32'd100, 32'd0, 32'd30, {1'b0, 32'd70});
    drive("R3 neg all", 2'd0, mk(2,1,0,0,1,1,1), 32'h00050000, 32'h00000007, 32'h11);
    // R5 right shift keeps carry
    issue("R5 rshift carry", 2'd0, mk(0,0,0,1,0,0,0), 32'hFFFFFFFF, 32'd1, 32'd0, {1'b0, 32'h00010000});
    drive("R5 rshift plus C", 2'd0, mk(0,0,0,1,0,0,0), 32'h80000000, 32'h80030000, 32'h5);
    // R6 left shift drops upper bits
    issue("R6 lshift drop", 2'd0, mk(0,0,0,2,0,0,0), 32'h00012345, 32'h00000001, 32'd7, {1'b0, 32'h23460007});
    drive("R6 lshift neg", 2'd0, mk(0,0,0,2,1,0,0), 32'd1, 32'd0, 32'd0);
    // R7 reserved codes
    issue("R7 mode3 as mode0", 2'd0, mk(0,0,0,3,0,0,0), 32'd1, 32'd2, 32'd3, {1'b1, 32'd6});
    issue("R7 height3 as full", 2'd0, mk(0,3,0,0,0,0,0), 32'd0, 32'h12345678, 32'd0, {1'b1, 32'h12345678});
    // R1 non-register forms ignore height, mode
    issue("R1 const ignores fields", 2'd1, mk(1,2,3,2,0,0,0), 32'h00010001, 32'h00020000, 32'd3, {1'b0, 32'h00030004});
    issue("R1 imm ignores mode3", 2'd2, mk(3,3,3,3,0,1,0), 32'd50, 32'd8, 32'd1, {1'b0, 32'd43});
    drive("R1 form3 plain", 2'd3, mk(2,2,2,1,1,0,1), 32'h1234, 32'h99, 32'h7);
    idle();
    idle();
    // R8 no out_valid while idle
    check("R8 idle out_valid", {32'd0, out_valid}, 33'd0);
    // R10 hold
    held = result;
    repeat (3) idle();
    check("R10 result held", {1'b0, result}, {1'b0, held});

    // several more patterns back to back
    for (int i = 0; i < 20; i++) begin
      logic [31:0] a = 32'h9E3779B9 * (i + 1);
      logic [31:0] b = 32'h7F4A7C15 ^ (a << 3);
      logic [31:0] c = a + 32'h01234567 * i;
      drive("R2 R3 R5 R6 sweep", 2'(i % 4 == 3 ? 1 : 0),
            mk(2'(i % 3), 2'((i + 1) % 3), 2'((i + 2) % 3), 2'(i % 3),
               i[0], i[1], i[2]), a, b, c);
    end
    idle();

    // R9 reset during a request
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R9 reset blocks valid", {32'd0, out_valid}, 33'd0);
    rst = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 queue drained", 33'(exp_q.size()), 33'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule